// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer programmed through a small register bus. Software loads a timeout in coarse ticks, clears the halt bit, and must then keep writing the reload register before the count runs out. Each `tickEn` pulse advances the countdown. If the countdown runs out once, the block sets a first-timeout flag and, when allowed, raises a management interrupt. It then reloads by itself and starts a second stage.

If the second stage also runs out with no reload in between, the block records a second-timeout flag and a boot flag and requests a system reset. The request is suppressed when the no-reboot bit is set. A hardware strap can lock the no-reboot bit to 1. The second-timeout flag is cleared only by the power-on reset, so software can tell after a restart that the watchdog caused it.

Register map (`busAddr`): 0 reload (any write reloads; a read returns the live count), 1 timeout, 2 status A (bit 0 first timeout), 3 status B (bit 0 second timeout, bit 1 boot), 4 control (bit 11 halt, bit 9 preserved), 5 interrupt enable (bit 0), 6 no-reboot (bit 0).

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, control reads 0x0800 (halt set), both status registers read 0, no-reboot reads 1, the timeout and the live count read 4, and `rstReq` and `smiOut` are low.
- R2: A write to the timeout register stores the low 8 bits when `extMode`=0 and all 16 bits when `extMode`=1. A resulting value of 0 or 1 is stored as 2.
- R3: While halt is clear, each cycle with `tickEn` high lowers the live count by one. With halt set, ticks leave the count unchanged.
- R4: Any write to the reload register, whatever its data, loads the live count from the timeout register and returns the block to the first stage.
- R5: The tick that finds a count of 1 in the first stage sets status A bit 0 and reloads the count. `smiOut` goes high one cycle later only if interrupt-enable bit 0 is set, and it stays high while both that bit and the flag are set.
- R6: Status flags are write-one-to-clear: writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: An expiry in the second stage sets status B bits 0 and 1. It also sets `rstReq` (held until reset) unless the effective no-reboot bit is 1.
- R8: A status B write clears at most one flag. When bits 0 and 1 are both written as 1, only bit 0 (second timeout) clears, and bit 1 needs a write of its own.
- R9: Control bit 9 holds the value last written to it, and every control bit other than 11 and 9 reads as 0.
- R10: While `noRebootLock` is high, no-reboot reads 1 even after a write of 0, and `rstReq` is never raised.
- R11: `rstN` clears every register except status B bit 0, which only `porN` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Async system reset, active low |
| porN | input | 1 | Async power-on reset, active low |
| tickEn | input | 1 | Countdown tick enable |
| extMode | input | 1 | 1 selects the 16-bit timeout, 0 the 8-bit timeout |
| noRebootLock | input | 1 | Hardware lock that forces no-reboot to 1 |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, zero when `busRd` is low |
| smiOut | output | 1 | Management interrupt |
| rstReq | output | 1 | System reset request |

## Verification
The hardest case to reach is a second-stage expiry whose effects must survive a system reset. The bench reaches it only by letting two full countdowns run out with no reload in between. Before that, it first proves that a reload issued mid-way through the second stage restarts the first stage instead. It then pulses `rstN` alone and reads status B, to show that the second-timeout flag survived while the boot flag and the reset request were cleared. Only after that does it pulse `porN`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W   = 16;
  localparam int LEG_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int MIN_TMO = 2;
  localparam int TMO_RST = 4;
  localparam int HALT_BIT = 11;
  localparam int KEEP_BIT = 9;

  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd0;
  localparam logic [ADDR_W-1:0] A_TMO    = 3'd1;
  localparam logic [ADDR_W-1:0] A_STSA   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STSB   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_INTEN  = 3'd5;
  localparam logic [ADDR_W-1:0] A_NORB   = 3'd6;

  typedef struct packed {
    logic reload;
    logic run;
    logic tick;
  } ctlStrobes_t;

  function automatic logic [CNT_W-1:0] clampTmo(input logic ext, input logic [CNT_W-1:0] d);
    logic [CNT_W-1:0] v;
    v = ext ? d : {{(CNT_W-LEG_W){1'b0}}, d[LEG_W-1:0]};
    if (v < CNT_W'(MIN_TMO)) v = CNT_W'(MIN_TMO);
    return v;
  endfunction
endpackage

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [CNT_W-1:0] tmoVal,
  output logic [CNT_W-1:0] count,
  output logic             expFirst,
  output logic             expSecond
);
  logic stage;
  logic expire;

  assign expire    = strb.tick && strb.run && !strb.reload && (count <= CNT_W'(1));
  assign expFirst  = expire && !stage;
  assign expSecond = expire && stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= CNT_W'(TMO_RST);
      stage <= 1'b0;
    end else if (strb.reload) begin
      count <= tmoVal;
      stage <= 1'b0;
    end else if (strb.tick && strb.run) begin
      if (count <= CNT_W'(1)) begin
        count <= tmoVal;
        stage <= 1'b1;
      end else begin
        count <= count - CNT_W'(1);
      end
    end
  end

  // R3
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN) count != '0);
  // R4
  reload_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> count == $past(tmoVal));
  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.reload) |=> $stable(count));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              tickEn,
  input  logic              extMode,
  input  logic              noRebootLock,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  input  logic [CNT_W-1:0]  count,
  input  logic              expFirst,
  input  logic              expSecond,
  output ctlStrobes_t       strb,
  output logic [CNT_W-1:0]  tmoVal,
  output logic              smiOut,
  output logic              rstReq
);
  logic halt, keepBit, intEn, noRebootReg, noRebootEff;
  logic firstTo, secondTo, bootSts;
  logic wrTmo, wrStsA, wrStsB, wrCtrl, wrInt, wrNorb;

  assign wrTmo  = busWr && busAddr == A_TMO;
  assign wrStsA = busWr && busAddr == A_STSA;
  assign wrStsB = busWr && busAddr == A_STSB;
  assign wrCtrl = busWr && busAddr == A_CTRL;
  assign wrInt  = busWr && busAddr == A_INTEN;
  assign wrNorb = busWr && busAddr == A_NORB;

  assign strb.reload = busWr && busAddr == A_RELOAD;
  assign strb.run    = !halt;
  assign strb.tick   = tickEn;

  assign noRebootEff = noRebootReg || noRebootLock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoVal      <= CNT_W'(TMO_RST);
      halt        <= 1'b1;
      keepBit     <= 1'b0;
      intEn       <= 1'b0;
      noRebootReg <= 1'b1;
      firstTo     <= 1'b0;
      bootSts     <= 1'b0;
      smiOut      <= 1'b0;
      rstReq      <= 1'b0;
    end else begin
      if (wrTmo) tmoVal <= clampTmo(extMode, busWrData);
      if (wrCtrl) begin
        halt    <= busWrData[HALT_BIT];
        keepBit <= busWrData[KEEP_BIT];
      end
      if (wrInt)  intEn <= busWrData[0];
      if (wrNorb) noRebootReg <= busWrData[0];
      if (expFirst) firstTo <= 1'b1;
      else if (wrStsA && busWrData[0]) firstTo <= 1'b0;
      if (expSecond) bootSts <= 1'b1;
      else if (wrStsB && busWrData[1] && !busWrData[0]) bootSts <= 1'b0;
      smiOut <= firstTo && intEn;
      if (expSecond && !noRebootEff) rstReq <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) secondTo <= 1'b0;
    else if (expSecond) secondTo <= 1'b1;
    else if (wrStsB && busWrData[0]) secondTo <= 1'b0;
  end

  always_comb begin
    busRdData = '0;
    if (busRd) begin
      case (busAddr)
        A_RELOAD: busRdData = count;
        A_TMO:    busRdData = tmoVal;
        A_STSA:   busRdData[0] = firstTo;
        A_STSB:   busRdData[1:0] = {bootSts, secondTo};
        A_CTRL: begin
          busRdData[HALT_BIT] = halt;
          busRdData[KEEP_BIT] = keepBit;
        end
        A_INTEN:  busRdData[0] = intEn;
        A_NORB:   busRdData[0] = noRebootEff;
        default:  busRdData = '0;
      endcase
    end
  end

  // R7
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    $rose(rstReq) |-> secondTo);
  // R10
  locked_no_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    noRebootLock |-> !$rose(rstReq));
  // R5
  smi_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smiOut) |-> $past(intEn) && $past(firstTo));
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        porN,
  input  logic        tickEn,
  input  logic        extMode,
  input  logic        noRebootLock,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [2:0]  busAddr,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  output logic        smiOut,
  output logic        rstReq
);
  logic sysRstN;
  ctlStrobes_t strb;
  logic [CNT_W-1:0] tmoVal, count;
  logic expFirst, expSecond;

  assign sysRstN = rstN && porN;

  wdt_regs u_regs (
    .clk(clk), .rstN(sysRstN), .porN(porN), .tickEn(tickEn), .extMode(extMode),
    .noRebootLock(noRebootLock), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .count(count), .expFirst(expFirst),
    .expSecond(expSecond), .strb(strb), .tmoVal(tmoVal), .smiOut(smiOut), .rstReq(rstReq)
  );

  wdt_core u_core (
    .clk(clk), .rstN(sysRstN), .strb(strb), .tmoVal(tmoVal), .count(count),
    .expFirst(expFirst), .expSecond(expSecond)
  );
endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0, porN = 1'b0, tickEn = 1'b0, extMode = 1'b0, noRebootLock = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic smiOut, rstReq;
  int nChk = 0, nFail = 0;

  always #2 clk = ~clk;

  wdt_two_stage u_dut (
    .clk(clk), .rstN(rstN), .porN(porN), .tickEn(tickEn), .extMode(extMode),
    .noRebootLock(noRebootLock), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .smiOut(smiOut), .rstReq(rstReq)
  );

  // {extMode, write data, expected stored timeout}
  localparam logic [32:0] TMO_VEC [0:8] = '{
    {1'b0, 16'h0000, 16'h0002}, {1'b0, 16'h0001, 16'h0002}, {1'b0, 16'h0123, 16'h0023},
    {1'b0, 16'h0101, 16'h0002}, {1'b0, 16'h00FF, 16'h00FF}, {1'b1, 16'h1234, 16'h1234},
    {1'b1, 16'h0001, 16'h0002}, {1'b1, 16'hFFFF, 16'hFFFF}, {1'b1, 16'h0003, 16'h0003}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    busRd = 1'b1; busAddr = a; #1; d = busRdData; busRd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    idle(3); rstN = 1'b1; porN = 1'b1; idle(1);
    // R1 reset state
    rd(3'd4, d); chk("R1 ctrl", d, 16'h0800);
    rd(3'd2, d); chk("R1 stsA", d, 16'h0000);
    rd(3'd3, d); chk("R1 stsB", d, 16'h0000);
    rd(3'd6, d); chk("R1 noReboot", d, 16'h0001);
    rd(3'd1, d); chk("R1 timeout", d, 16'h0004);
    rd(3'd0, d); chk("R1 count", d, 16'h0004);
    chk("R1 rstReq", {15'd0, rstReq}, 16'h0000);
    chk("R1 smiOut", {15'd0, smiOut}, 16'h0000);
    // R9 preserved control bit
    wr(3'd4, 16'h0AFF); rd(3'd4, d); chk("R9 ctrl bit9 set", d, 16'h0A00);
    wr(3'd4, 16'h0200); rd(3'd4, d); chk("R9 ctrl halt clear", d, 16'h0200);
    wr(3'd4, 16'h0800);
    // R2 timeout clamp and width table
    foreach (TMO_VEC[i]) begin
      extMode = TMO_VEC[i][32];
      wr(3'd1, TMO_VEC[i][31:16]);
      rd(3'd1, d); chk("R2 timeout store", d, TMO_VEC[i][15:0]);
    end
    // R3 countdown and halt
    extMode = 1'b1;
    wr(3'd1, 16'h0003); wr(3'd0, 16'hABCD);
    rd(3'd0, d); chk("R4 reload count", d, 16'h0003);
    wr(3'd4, 16'h0000);
    ticks(1); rd(3'd0, d); chk("R3 count after 1 tick", d, 16'h0002);
    ticks(1); rd(3'd0, d); chk("R3 count after 2 ticks", d, 16'h0001);
    wr(3'd4, 16'h0800); ticks(2); rd(3'd0, d); chk("R3 halted count", d, 16'h0001);
    wr(3'd4, 16'h0000);
    // R5 first expiry
    ticks(1); rd(3'd2, d); chk("R5 first flag", d, 16'h0001);
    rd(3'd0, d); chk("R5 auto reload", d, 16'h0003);
    idle(2); chk("R5 smi masked", {15'd0, smiOut}, 16'h0000);
    wr(3'd5, 16'h0001); idle(2); chk("R5 smi enabled", {15'd0, smiOut}, 16'h0001);
    // R6 write-one-to-clear
    wr(3'd2, 16'h0000); rd(3'd2, d); chk("R6 zero keeps flag", d, 16'h0001);
    wr(3'd2, 16'h0001); rd(3'd2, d); chk("R6 one clears flag", d, 16'h0000);
    idle(2); chk("R6 smi drops", {15'd0, smiOut}, 16'h0000);
    // R4 reload in second stage returns to first stage
    ticks(1); wr(3'd0, 16'h0000); rd(3'd0, d); chk("R4 reload any data", d, 16'h0003);
    ticks(3); rd(3'd2, d); chk("R4 first stage again", d, 16'h0001);
    rd(3'd3, d); chk("R4 no second flag", d, 16'h0000);
    wr(3'd2, 16'h0001);
    // R7 second expiry with reboot allowed
    wr(3'd6, 16'h0000); rd(3'd6, d); chk("R7 noReboot cleared", d, 16'h0000);
    ticks(3); rd(3'd3, d); chk("R7 second flags", d, 16'h0003);
    chk("R7 rstReq", {15'd0, rstReq}, 16'h0001);
    // R11 system reset keeps second-timeout flag
    @(negedge clk); rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    chk("R11 rstReq cleared", {15'd0, rstReq}, 16'h0000);
    rd(3'd3, d); chk("R11 second flag survives", d, 16'h0001);
    rd(3'd4, d); chk("R11 halt back", d, 16'h0800);
    // R8 separate clears, and R7 blocked by noReboot
    wr(3'd4, 16'h0000); ticks(8);
    rd(3'd3, d); chk("R8 both flags", d, 16'h0003);
    chk("R7 blocked by noReboot", {15'd0, rstReq}, 16'h0000);
    wr(3'd3, 16'h0003); rd(3'd3, d); chk("R8 one clear only", d, 16'h0002);
    wr(3'd3, 16'h0002); rd(3'd3, d); chk("R8 boot own write", d, 16'h0000);
    ticks(4); rd(3'd3, d); chk("R11 set before por", d, 16'h0003);
    @(negedge clk); porN = 1'b0; @(negedge clk); porN = 1'b1;
    rd(3'd3, d); chk("R11 por clears", d, 16'h0000);
    // R10 hardware lock
    noRebootLock = 1'b1;
    wr(3'd6, 16'h0000); rd(3'd6, d); chk("R10 locked reads 1", d, 16'h0001);
    wr(3'd4, 16'h0000); wr(3'd0, 16'h0000); ticks(8);
    rd(3'd3, d); chk("R10 second expiry seen", d, 16'h0003);
    chk("R10 no reset", {15'd0, rstReq}, 16'h0000);
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule